// File: doc/BRIEF.md
# Pulse-Width Single-Wire Bus Slave

The block is the slave end of a single open-drain wire on which every bit starts with the master pulling the line low. The length of each low pulse carries the symbol: a short pulse is a sync, a medium one is a 0 and a long one is a 1. The slave first waits for a run of sync pulses. It then collects the direction flag, the target address and the register address, and checks them against a parity bit. A frame addressed to it is treated as a write or as a read, depending on the top bit of the register address.

On a write the slave receives a data byte and its parity bit. It stores the byte in a small register file only when both parity bits are correct. In the last slot it answers with an acknowledge. On a read the master sends only sync pulses. The slave stretches each one so that the line stays low for the length of a 0 or a 1, and in this way returns the register byte, its parity and the acknowledge. The block needs no host. Its only configuration is the address input it answers to.

Top module: `pwm_slave_responder`

## Requirements
- R1: While `rst` is high and in the cycle after it, `bus_pull` is 0. With `UNIT` clock cycles per time unit, a line low time L (in cycles) is classified as follows: a sync for L < 2·UNIT, a 0 for 2·UNIT ≤ L ≤ 4·UNIT, a 1 for 5·UNIT ≤ L ≤ 7·UNIT, and invalid otherwise.
- R2: A 0 or 1 sent at either end of its accepted window (2·UNIT or 4·UNIT for a 0, 5·UNIT or 7·UNIT for a 1) decodes the same way as the nominal 3·UNIT or 6·UNIT.
- R3: Frame decoding starts only with a data bit that follows at least three back-to-back sync pulses. After only two syncs, the frame is ignored.
- R4: The header is 8 bits: direction flag, then the 3-bit slave address MSB first, then the 4-bit register address MSB first. The frame is accepted only when the direction flag is 0 and the address equals `my_addr`.
- R5: The header is followed by the first parity bit, which is 1 when the 8 header bits hold an odd count of ones. A mismatch makes the acknowledge 1. On a read with bad header parity, the data and second-parity slots are left undriven.
- R6: Register address bit 3 = 1 means write. The master then sends 8 data bits MSB first and the second parity bit (1 for an odd count of ones in the data). The byte is stored in register `reg_addr[2:0]` only when both parity bits are correct, and the acknowledge is then 0.
- R7: Register address bit 3 = 0 means read. The slave answers in 10 master-started slots: 8 data bits MSB first, then the parity, then an acknowledge of 0. It pulls the line within 3 cycles of the master's falling edge and releases it so that the line is low for exactly 3·UNIT cycles (0) or 6·UNIT cycles (1). `bus_pull` is never held longer than 6·UNIT cycles.
- R8: A second-parity error on a write gives an acknowledge of 1 and leaves the register unchanged.
- R9: A frame with the wrong address or with the direction flag set is never driven. The slave lets the 10 body slots pass and then hunts for a new pause.
- R10: An invalid pulse length anywhere in a frame aborts it: nothing is driven or stored, and a fresh pause is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 1 | Sensed level of the shared line (0 = low) |
| my_addr | input | 3 | Slave address this node answers to |
| bus_pull | output | 1 | 1 pulls the shared line low |

## Verification
All eight registers are written with distinct bytes and read back. This tells apart register indexing, bit order and parity generation, since each read returns a slot-by-slot pattern of exact low lengths. Writes aimed at the seven other addresses and at the other direction show whether address and direction matching are kept apart. Each parity flip and the two-sync pause tell whether the acknowledge and the storage depend on the correct condition. Pulses at the four tolerance edges and at two invalid lengths separate the class boundaries.

// File: rtl/pwm_slave_pkg.sv
package pwm_slave_pkg;
  typedef enum logic [1:0] {PC_SYNC, PC_ZERO, PC_ONE, PC_BAD} pulse_cls_t;
  typedef enum logic [1:0] {ST_HUNT, ST_HDR, ST_PAR, ST_BODY} frame_st_t;
  typedef enum logic [1:0] {MD_RX, MD_TX, MD_SKIP, MD_IGN} body_md_t;
endpackage

// File: rtl/pwm_pulse_meter.sv
module pwm_pulse_meter
  import pwm_slave_pkg::*;
#(
  parameter int UNIT = 8,
  parameter int CW   = $clog2(8 * UNIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_in,
  output logic          fall,
  output logic          done,
  output pulse_cls_t    cls,
  output logic [CW-1:0] len
);
  localparam logic [CW-1:0] LEN_MAX = CW'(8 * UNIT);
  localparam logic [CW-1:0] ZERO_LO = CW'(2 * UNIT);
  localparam logic [CW-1:0] ZERO_HI = CW'(4 * UNIT);
  localparam logic [CW-1:0] ONE_LO  = CW'(5 * UNIT);
  localparam logic [CW-1:0] ONE_HI  = CW'(7 * UNIT);

  logic s1, s2, s2_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      s2_d <= 1'b1;
      len  <= '0;
    end else begin
      s1   <= line_in;
      s2   <= s1;
      s2_d <= s2;
      if (s2)
        len <= '0;
      else if (len != LEN_MAX)
        len <= len + 1'b1;
    end
  end

  assign fall = !s2 && s2_d;
  assign done = s2 && !s2_d;

  always_comb begin
    if (len < ZERO_LO)                       cls = PC_SYNC;
    else if (len <= ZERO_HI)                 cls = PC_ZERO;
    else if (len >= ONE_LO && len <= ONE_HI) cls = PC_ONE;
    else                                     cls = PC_BAD;
  end
endmodule

// File: rtl/pwm_slave_regfile.sv
module pwm_slave_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pwm_slave_responder.sv
module pwm_slave_responder
  import pwm_slave_pkg::*;
#(
  parameter int UNIT      = 8,
  parameter int ADDR_W    = 3,
  parameter int REG_W     = 4,
  parameter int DATA_W    = 8,
  parameter int PAUSE_MIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_in,
  input  logic [ADDR_W-1:0] my_addr,
  output logic              bus_pull
);
  localparam int HDR_W = 1 + ADDR_W + REG_W;
  localparam int IDX_W = REG_W - 1;
  localparam int CW    = $clog2(8 * UNIT + 1);
  localparam int LAST  = DATA_W + 1;
  localparam int SW    = $clog2(LAST + 1);
  localparam int BW    = $clog2(HDR_W + 1);
  localparam int PW    = $clog2(PAUSE_MIN + 1);
  localparam logic [CW-1:0] HOLD0 = CW'(3 * UNIT - 3);
  localparam logic [CW-1:0] HOLD1 = CW'(6 * UNIT - 3);

  logic          fall, done;
  pulse_cls_t    cls;
  logic [CW-1:0] len;

  pwm_pulse_meter #(.UNIT(UNIT), .CW(CW)) u_meter (
    .clk(clk), .rst(rst), .line_in(bus_in),
    .fall(fall), .done(done), .cls(cls), .len(len)
  );

  frame_st_t         state;
  body_md_t          mode;
  logic [PW-1:0]     syncs;
  logic [HDR_W-1:0]  hdr;
  logic [BW-1:0]     bitn;
  logic [SW-1:0]     slot;
  logic [DATA_W-1:0] shreg;
  logic              txpar, ack_bit, pull, wr_en;
  logic [CW-1:0]     hold;
  logic [DATA_W-1:0] rdata;

  pwm_slave_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .we(wr_en), .waddr(hdr[IDX_W-1:0]), .wdata(shreg),
    .raddr(hdr[IDX_W-1:0]), .rdata(rdata)
  );

  logic is_bit, bitv, drive_slot, tx_bit, hdr_match, hdr_par, body_ignore;
  assign is_bit    = (cls == PC_ZERO) || (cls == PC_ONE);
  assign bitv      = (cls == PC_ONE);
  assign hdr_match = !hdr[HDR_W-1] && (hdr[HDR_W-2 -: ADDR_W] == my_addr);
  assign hdr_par   = ^hdr;
  assign drive_slot = (mode == MD_TX) ||
                      (((mode == MD_RX) || (mode == MD_SKIP)) && (slot == SW'(LAST)));
  assign body_ignore = (state == ST_BODY) && (mode == MD_IGN);

  always_comb begin
    if (slot == SW'(LAST))        tx_bit = ack_bit;
    else if (slot == SW'(DATA_W)) tx_bit = txpar;
    else                          tx_bit = shreg[DATA_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      mode    <= MD_IGN;
      syncs   <= '0;
      hdr     <= '0;
      bitn    <= '0;
      slot    <= '0;
      shreg   <= '0;
      txpar   <= 1'b0;
      ack_bit <= 1'b0;
      pull    <= 1'b0;
      hold    <= '0;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (pull && len == hold) pull <= 1'b0;
      if (fall && state == ST_BODY && drive_slot) begin
        pull <= 1'b1;
        hold <= tx_bit ? HOLD1 : HOLD0;
      end
      if (done) begin
        unique case (state)
          ST_HUNT: begin
            if (cls == PC_SYNC) begin
              if (syncs != PW'(PAUSE_MIN)) syncs <= syncs + 1'b1;
            end else if (is_bit && syncs == PW'(PAUSE_MIN)) begin
              hdr   <= {{(HDR_W-1){1'b0}}, bitv};
              bitn  <= BW'(1);
              state <= ST_HDR;
            end else begin
              syncs <= '0;
            end
          end
          ST_HDR: begin
            if (is_bit) begin
              hdr  <= {hdr[HDR_W-2:0], bitv};
              bitn <= bitn + 1'b1;
              if (bitn == BW'(HDR_W - 1)) state <= ST_PAR;
            end else begin
              state <= ST_HUNT;
              syncs <= (cls == PC_SYNC) ? PW'(1) : '0;
            end
          end
          ST_PAR: begin
            if (is_bit) begin
              state   <= ST_BODY;
              slot    <= '0;
              ack_bit <= 1'b1;
              if (!hdr_match)            mode <= MD_IGN;
              else if (bitv != hdr_par)  mode <= MD_SKIP;
              else if (hdr[REG_W-1])     mode <= MD_RX;
              else begin
                mode    <= MD_TX;
                shreg   <= rdata;
                txpar   <= ^rdata;
                ack_bit <= 1'b0;
              end
            end else begin
              state <= ST_HUNT;
              syncs <= (cls == PC_SYNC) ? PW'(1) : '0;
            end
          end
          ST_BODY: begin
            if (cls == PC_BAD ||
                (mode == MD_RX && slot <= SW'(DATA_W) && !is_bit)) begin
              state <= ST_HUNT;
              syncs <= (cls == PC_SYNC) ? PW'(1) : '0;
            end else begin
              if (mode == MD_RX) begin
                if (slot < SW'(DATA_W)) shreg <= {shreg[DATA_W-2:0], bitv};
                else if (slot == SW'(DATA_W)) begin
                  ack_bit <= (bitv != ^shreg);
                  wr_en   <= (bitv == ^shreg);
                end
              end
              if (mode == MD_TX && slot < SW'(DATA_W))
                shreg <= {shreg[DATA_W-2:0], 1'b0};
              if (slot == SW'(LAST)) begin
                state <= ST_HUNT;
                syncs <= '0;
              end else begin
                slot <= slot + 1'b1;
              end
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assign bus_pull = pull;
endmodule

// File: rtl/pwm_slave_checker.sv
module pwm_slave_checker #(
  parameter int UNIT = 8
) (
  input logic clk,
  input logic rst,
  input logic bus_in,
  input logic bus_pull,
  input logic body_ignore
);
  localparam int RW = $clog2(8 * UNIT + 1);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || !bus_pull) run <= '0;
    else if (run != RW'(8 * UNIT)) run <= run + 1'b1;
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) rst |=> !bus_pull);

  // R7
  drive_in_master_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_pull) |-> !bus_in);

  // R7
  hold_limit_chk: assert property (@(posedge clk) disable iff (rst)
    run <= RW'(6 * UNIT));

  // R9
  silent_when_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    body_ignore |-> !bus_pull);
endmodule

bind pwm_slave_responder pwm_slave_checker #(.UNIT(UNIT)) u_chk (
  .clk(clk), .rst(rst), .bus_in(bus_in), .bus_pull(bus_pull),
  .body_ignore(body_ignore)
);

// File: tb/pwm_slave_responder_test.sv
module pwm_slave_responder_test;
  localparam int CLK_P = 10;
  localparam int U     = 8;
  localparam int MY    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_pull = 1'b0;
  logic bus_pull;
  logic line;
  logic [2:0] my_addr = 3'(MY);

  assign line = !(m_pull || bus_pull);
  always #(CLK_P/2) clk = ~clk;

  pwm_slave_responder #(.UNIT(U)) uut (
    .clk(clk), .rst(rst), .bus_in(line), .my_addr(my_addr), .bus_pull(bus_pull)
  );

  int errors = 0;
  int checks = 0;
  int zlen = 3 * U;
  int olen = 6 * U;
  int blen [10];
  int model [8];
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic slot(input int l, output int low);
    @(posedge clk); #1 m_pull = 1'b1;
    low = 0;
    for (int i = 0; i < l; i++) begin
      @(negedge clk);
      if (!line) low++;
    end
    @(posedge clk); #1 m_pull = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!line) low++;
      else break;
    end
    repeat (2 * U) @(posedge clk);
  endtask

  task automatic frame(input int npause, input bit dir, input int addr, input int rg,
                       input bit p1flip, input int data, input bit p2flip,
                       input int badpos, input int badlen);
    logic [7:0] h;
    logic [7:0] d;
    int dummy;
    h = {dir, 3'(addr), 4'(rg)};
    d = 8'(data);
    for (int i = 0; i < npause; i++) slot(U, dummy);
    for (int i = 7; i >= 0; i--)
      slot((badpos == 7 - i) ? badlen : (h[i] ? olen : zlen), dummy);
    slot(((^h) ^ p1flip) ? olen : zlen, dummy);
    if (h[3]) begin
      for (int i = 7; i >= 0; i--) slot(d[i] ? olen : zlen, blen[7 - i]);
      slot(((^d) ^ p2flip) ? olen : zlen, blen[8]);
      slot(U, blen[9]);
    end else begin
      for (int j = 0; j < 10; j++) slot(U, blen[j]);
    end
  endtask

  function automatic int dec(input int l);
    if (l == 3 * U) return 0;
    if (l == 6 * U) return 1;
    if (l == U) return 2;
    return -1;
  endfunction

  task automatic wr(input int r, input int v, input string tag);
    frame(3, 1'b0, MY, 8 | r, 1'b0, v, 1'b0, -1, 0);
    chk(dec(blen[9]) == 0, tag, dec(blen[9]), 0);
    model[r] = v;
  endtask

  task automatic rd(input int r, input string tag);
    int val;
    bit okb;
    frame(3, 1'b0, MY, r, 1'b0, 0, 1'b0, -1, 0);
    val = 0;
    okb = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (dec(blen[i]) > 1) okb = 1'b0;
      val = (val << 1) | (dec(blen[i]) & 1);
    end
    chk(okb && val == model[r], {tag, " data"}, val, model[r]);
    chk(dec(blen[8]) == ($countones(val) & 1), "R7 read parity", dec(blen[8]),
        $countones(model[r]) & 1);
    chk(dec(blen[9]) == 0, "R7 read ack", dec(blen[9]), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(bus_pull == 1'b0, "R1 pull during reset", int'(bus_pull), 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(bus_pull == 1'b0, "R1 pull after reset", int'(bus_pull), 0);
    repeat (4 * U) @(posedge clk);

    // R6: write every register, R7: read every register back
    for (int r = 0; r < 8; r++) wr(r, (r * 53 + 29) & 255, "R6 write ack");
    for (int r = 0; r < 8; r++) rd(r, "R7 read");

    // R9: other addresses never answered, data untouched
    for (int a = 0; a < 8; a++) begin
      if (a == MY) continue;
      frame(3, 1'b0, a, 8 | 1, 1'b0, 8'h0F, 1'b0, -1, 0);
      chk(dec(blen[9]) == 2, "R9 foreign address ack slot", blen[9], U);
    end
    frame(3, 1'b0, (MY + 1) & 7, 2, 1'b0, 0, 1'b0, -1, 0);
    begin
      bit quiet = 1'b1;
      for (int j = 0; j < 10; j++) if (blen[j] != U) quiet = 1'b0;
      chk(quiet, "R9 foreign read stays silent", int'(quiet), 1);
    end
    // R4: direction flag set is ignored
    frame(3, 1'b1, MY, 8 | 1, 1'b0, 8'h33, 1'b0, -1, 0);
    chk(dec(blen[9]) == 2, "R4 direction flag ignored", blen[9], U);
    rd(1, "R9 reg1 after foreign frames");

    // R5: bad header parity on write and read
    frame(3, 1'b0, MY, 8 | 2, 1'b1, 8'hC3, 1'b0, -1, 0);
    chk(dec(blen[9]) == 1, "R5 bad P1 write ack", blen[9], 6 * U);
    frame(3, 1'b0, MY, 2, 1'b1, 0, 1'b0, -1, 0);
    begin
      bit quiet = 1'b1;
      for (int j = 0; j < 9; j++) if (blen[j] != U) quiet = 1'b0;
      chk(quiet, "R5 bad P1 read no data", int'(quiet), 1);
    end
    chk(dec(blen[9]) == 1, "R5 bad P1 read ack", blen[9], 6 * U);
    // R8: bad data parity
    frame(3, 1'b0, MY, 8 | 2, 1'b0, 8'h5A, 1'b1, -1, 0);
    chk(dec(blen[9]) == 1, "R8 bad P2 ack", blen[9], 6 * U);
    rd(2, "R8 reg2 unchanged");

    // R3: only two syncs
    frame(2, 1'b0, MY, 8 | 3, 1'b0, 8'h81, 1'b0, -1, 0);
    chk(dec(blen[9]) == 2, "R3 short pause ignored", blen[9], U);
    rd(3, "R3 reg3 unchanged");

    // R10: invalid pulse lengths in header
    frame(3, 1'b0, MY, 8 | 4, 1'b0, 8'h7E, 1'b0, 3, 4 * U + U / 2);
    chk(dec(blen[9]) == 2, "R10 gap length aborts", blen[9], U);
    frame(3, 1'b0, MY, 8 | 4, 1'b0, 8'h7E, 1'b0, 6, 8 * U);
    chk(dec(blen[9]) == 2, "R10 overlong aborts", blen[9], U);
    rd(4, "R10 reg4 unchanged");

    // R2: tolerance edges
    zlen = 2 * U; olen = 7 * U;
    wr(5, 8'hA5, "R2 outer edges write ack");
    zlen = 4 * U; olen = 5 * U;
    wr(6, 8'h3C, "R2 inner edges write ack");
    zlen = 3 * U; olen = 6 * U;
    rd(5, "R2 outer edges read");
    rd(6, "R2 inner edges read");

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule